// File: doc/BRIEF.md
# Programmable Skew and Divide Clock Output Matrix

This block produces eight clock outputs from one fast tick clock. The outputs form four groups of two, and both outputs of a group always carry the same waveform. A free-running phase counter splits time into base periods of 16 time units. One time unit is `TICKS_PER_TU` tick cycles. Each undivided output has a 50% duty cycle and repeats once per base period. The reference (zero-skew) waveform is high for the first half of every base period.

Each group has two three-level select codes, `sel_a` and `sel_b`. The pair of codes sets the group's timing:
- a shift, in whole time units, earlier or later than the reference phase;
- for the fourth group only, an inverted reference;
- for the third and fourth groups only, division by two or by four. The divided waveforms are locked to base-period boundaries, and their falling edges coincide.

A change on any select starts a resynchronising blank. During the blank all outputs are held low. When the blank ends, the divider phase restarts from a known point.

Top module: `skew_out_matrix`

## Requirements
- R1: Group g (g = 0..3) drives `clk_out[2g]` and `clk_out[2g+1]`, and these two bits are equal on every cycle. The group's selects are `sel_a[2g+1:2g]` and `sel_b[2g+1:2g]`.
- R2: Select codes are encoded as 0 = LOW, 1 = MID and 2 = HIGH. Code 3 is treated as MID. With MID/MID, a group is high exactly when the base-period phase lies in the first half of the period. `clk_out` is a register, so it shows the phase of the previous tick.
- R3: A shift of d time units delays the rising edge by d·`TICKS_PER_TU` ticks, modulo the period. The codes (a/b) map to shifts as follows: LOW/LOW −4, LOW/MID −3, LOW/HIGH −2, MID/LOW −1, MID/HIGH +6. On groups 0 to 2, HIGH/HIGH gives +3.
- R4: On group 3, HIGH/HIGH gives the reference waveform inverted, which is high in the second half of each base period.
- R5: On groups 2 and 3, HIGH/MID divides by two and HIGH/LOW divides by four. Both are constant within a base period. The divide-by-2 output is high in odd-numbered periods. The divide-by-4 output is high in periods 2 and 3 of every four. Every falling edge of the divide-by-4 output coincides with a falling edge of the divide-by-2 output.
- R6: On groups 0 and 1, HIGH/LOW and HIGH/MID are shifts of +1 and +2 time units.
- R7: The selects are registered. A tick on which any select differs from its registered value blanks all outputs low. The blank starts on the next output update and lasts through the second base-period boundary after that tick. A further change during a blank restarts the window.
- R8: Base-period numbering for R5 restarts at 0 in the first period after a blank ends.
- R9: While reset is high, and for the whole first base period after reset falls, all outputs are low. Reset captures the selects without starting a blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_a | input | 8 | First select code of each group, 2 bits per group |
| sel_b | input | 8 | Second select code of each group, 2 bits per group |
| clk_out | output | 8 | Clock outputs, two per group |

## Verification
The hardest situations to reach are select changes that land exactly on a base-period boundary, and a second change that arrives while a blank is still running. Both of these move the end of the window and the restart of the divider numbering.

The stimulus rotates every code pair across all four groups, with hold times that vary the phase at which each change lands. One change is placed deliberately on a period boundary, and one pair of changes is issued five ticks apart. Expected waveforms are derived from the tick count, the change instants and the code table alone.

// File: rtl/skew_pkg.sv
package skew_pkg;

  typedef enum logic [1:0] {
    M_SHIFT = 2'd0,
    M_INV   = 2'd1,
    M_DIV2  = 2'd2,
    M_DIV4  = 2'd3
  } lane_mode_e;

  typedef struct packed {
    lane_mode_e        mode;
    logic signed [4:0] tu;
  } lane_cfg_t;

  // Three-level code pair to lane timing; code 3 is read as MID.
  function automatic lane_cfg_t decode_sel(input logic [1:0] a, input logic [1:0] b,
                                           input logic can_div, input logic can_inv);
    lane_cfg_t c;
    logic [1:0] an;
    logic [1:0] bn;
    an = (a == 2'd3) ? 2'd1 : a;
    bn = (b == 2'd3) ? 2'd1 : b;
    c.mode = M_SHIFT;
    c.tu   = 5'sd0;
    case ({an, bn})
      4'b0000: c.tu = -5'sd4;
      4'b0001: c.tu = -5'sd3;
      4'b0010: c.tu = -5'sd2;
      4'b0100: c.tu = -5'sd1;
      4'b0110: c.tu = 5'sd6;
      4'b1000: if (can_div) c.mode = M_DIV4; else c.tu = 5'sd1;
      4'b1001: if (can_div) c.mode = M_DIV2; else c.tu = 5'sd2;
      4'b1010: if (can_inv) c.mode = M_INV;  else c.tu = 5'sd3;
      default: c.tu = 5'sd0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/skew_phase_gen.sv
module skew_phase_gen #(
  parameter int PERIOD = 32,
  parameter int PW     = 5,
  parameter int SELW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SELW-1:0] sel_a,
  input  logic [SELW-1:0] sel_b,
  output logic [SELW-1:0] sel_a_q,
  output logic [SELW-1:0] sel_b_q,
  output logic [PW-1:0]   ph,
  output logic [1:0]      div_cnt,
  output logic            blank
);
  logic [1:0] blank_rem;
  logic       wrap;
  logic       sel_change;

  assign wrap       = (ph == PW'(PERIOD - 1));
  assign sel_change = (sel_a != sel_a_q) || (sel_b != sel_b_q);
  assign blank      = (blank_rem != 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= '0;
      div_cnt   <= 2'd0;
      blank_rem <= 2'd1;
      sel_a_q   <= sel_a;
      sel_b_q   <= sel_b;
    end else begin
      ph      <= wrap ? '0 : ph + PW'(1);
      sel_a_q <= sel_a;
      sel_b_q <= sel_b;
      if (sel_change)
        blank_rem <= 2'd2;
      else if (wrap && blank)
        blank_rem <= blank_rem - 2'd1;
      if (wrap)
        div_cnt <= blank ? 2'd0 : div_cnt + 2'd1;
    end
  end

  a_r7_blank_on_change: assert property (@(posedge clk) disable iff (rst)
    sel_change |=> blank);
  a_r8_div_restart: assert property (@(posedge clk) disable iff (rst)
    (wrap && blank) |=> (div_cnt == 2'd0));
  a_r2_phase_wrap: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (ph == '0));
endmodule

// File: rtl/skew_lane.sv
module skew_lane
  import skew_pkg::*;
#(
  parameter int PERIOD       = 32,
  parameter int PW           = 5,
  parameter int TICKS_PER_TU = 2,
  parameter bit CAN_DIV      = 1'b0,
  parameter bit CAN_INV      = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    code_a,
  input  logic [1:0]    code_b,
  input  logic [PW-1:0] ph,
  input  logic [1:0]    div_cnt,
  input  logic          blank,
  output logic [1:0]    q
);
  localparam int HALF = PERIOD / 2;

  lane_cfg_t cfg;
  int        shift_ticks;
  int        rel;
  logic      wave;

  always_comb begin
    cfg         = decode_sel(code_a, code_b, CAN_DIV, CAN_INV);
    shift_ticks = int'(cfg.tu) * TICKS_PER_TU;
    if (shift_ticks < 0) shift_ticks = shift_ticks + PERIOD;
    rel = int'(ph) + PERIOD - shift_ticks;
    if (rel >= PERIOD) rel = rel - PERIOD;
    case (cfg.mode)
      M_INV:   wave = (int'(ph) >= HALF);
      M_DIV2:  wave = div_cnt[0];
      M_DIV4:  wave = div_cnt[1];
      default: wave = (rel < HALF);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 2'b00;
    end else begin
      q[0] <= wave & ~blank;
      q[1] <= wave & ~blank;
    end
  end
endmodule

// File: rtl/skew_out_matrix.sv
module skew_out_matrix #(
  parameter int TICKS_PER_TU  = 2,
  parameter int TU_PER_PERIOD = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] sel_a,
  input  logic [7:0] sel_b,
  output logic [7:0] clk_out
);
  localparam int GROUPS = 4;
  localparam int SELW   = 2 * GROUPS;
  localparam int PERIOD = TICKS_PER_TU * TU_PER_PERIOD;
  localparam int PW     = $clog2(PERIOD);

  logic [SELW-1:0] sel_a_q;
  logic [SELW-1:0] sel_b_q;
  logic [PW-1:0]   ph;
  logic [1:0]      div_cnt;
  logic            blank;

  skew_phase_gen #(.PERIOD(PERIOD), .PW(PW), .SELW(SELW)) phase_i (
    .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b),
    .sel_a_q(sel_a_q), .sel_b_q(sel_b_q), .ph(ph),
    .div_cnt(div_cnt), .blank(blank)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_lane
    localparam bit LANE_DIV = (g >= 2);
    localparam bit LANE_INV = (g == 3);
    skew_lane #(
      .PERIOD(PERIOD), .PW(PW), .TICKS_PER_TU(TICKS_PER_TU),
      .CAN_DIV(LANE_DIV), .CAN_INV(LANE_INV)
    ) lane_i (
      .clk(clk), .rst(rst),
      .code_a(sel_a_q[2*g+1:2*g]), .code_b(sel_b_q[2*g+1:2*g]),
      .ph(ph), .div_cnt(div_cnt), .blank(blank),
      .q(clk_out[2*g+1:2*g])
    );

    a_r1_pair_match: assert property (@(posedge clk) disable iff (rst)
      clk_out[2*g] == clk_out[2*g+1]);
  end

  a_r7_blank_low: assert property (@(posedge clk) disable iff (rst)
    blank |=> (clk_out == 8'h00));
  a_r9_reset_low: assert property (@(posedge clk)
    rst |=> (clk_out == 8'h00));
endmodule

// File: tb/skew_out_matrix_tb.sv
module skew_out_matrix_tb_top;
  localparam int T = 2;
  localparam int P = 16 * T;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] sel_a = 8'h55;
  logic [7:0] sel_b = 8'h55;
  logic [7:0] clk_out;

  int checks = 0;
  int fails  = 0;
  int j = 0;
  int c_edge = 0, e2 = P, prev_e2 = P;
  logic [7:0] cur_a = 8'h55, cur_b = 8'h55, prev_a = 8'h55, prev_b = 8'h55;

  always #4 clk = ~clk;

  skew_out_matrix #(.TICKS_PER_TU(T), .TU_PER_PERIOD(16)) dut_i (
    .clk(clk), .rst(rst), .sel_a(sel_a), .sel_b(sel_b), .clk_out(clk_out)
  );

  // Waveform of group g from the code table; q = phase, k = period number since resync.
  function automatic void lane_model(input int g, input int a, input int b, input int jj,
                                     input int ep, output bit v, output string tag);
    int q, k, d, x;
    q = (jj - 1) % P;
    k = ((jj - 1 - ep) / P) % 4;
    if (a == 3) a = 1;
    if (b == 3) b = 1;
    d = 0; tag = "R3";
    case (a * 3 + b)
      0: d = -4;
      1: d = -3;
      2: d = -2;
      3: d = -1;
      4: begin d = 0; tag = "R2"; end
      5: d = 6;
      6: begin d = 1; tag = (g < 2) ? "R6" : "R3"; end
      7: begin d = 2; tag = (g < 2) ? "R6" : "R3"; end
      default: d = 3;
    endcase
    x = (((q - d * T) % P) + P) % P;
    v = (x < P / 2);
    if (g >= 2 && a == 2 && b == 1) begin
      v = k[0]; tag = (jj - 1 - ep < 4 * P) ? "R8" : "R5";
    end else if (g >= 2 && a == 2 && b == 0) begin
      v = k[1]; tag = (jj - 1 - ep < 4 * P) ? "R8" : "R5";
    end else if (g == 3 && a == 2 && b == 2) begin
      v = (q >= P / 2); tag = "R4";
    end
  endfunction

  task automatic check_sample();
    for (int g = 0; g < 4; g++) begin
      bit    v;
      string tag;
      if (j <= c_edge) begin
        if (j <= prev_e2) begin v = 1'b0; tag = (prev_e2 == P) ? "R9" : "R7"; end
        else lane_model(g, int'(prev_a[2*g+:2]), int'(prev_b[2*g+:2]), j, prev_e2, v, tag);
      end else if (j <= e2) begin
        v = 1'b0; tag = (e2 == P) ? "R9" : "R7";
      end else begin
        lane_model(g, int'(cur_a[2*g+:2]), int'(cur_b[2*g+:2]), j, e2, v, tag);
      end
      checks++;
      if (clk_out[2*g] !== v) begin
        fails++;
        $display("FAIL %s group %0d tick %0d: got %b expected %b", tag, g, j, clk_out[2*g], v);
      end
    end
    checks++;
    for (int g = 0; g < 4; g++) begin
      if (clk_out[2*g] !== clk_out[2*g+1]) begin
        fails++;
        $display("FAIL R1 group %0d tick %0d: got %b%b expected equal pair", g, j,
                 clk_out[2*g+1], clk_out[2*g]);
      end
    end
  endtask

  task automatic run(input int n);
    repeat (n) begin
      @(posedge clk);
      j++;
      @(negedge clk);
      check_sample();
    end
  endtask

  task automatic change(input logic [7:0] na, input logic [7:0] nb);
    prev_a = cur_a; prev_b = cur_b; prev_e2 = e2;
    c_edge = j + 1;
    e2 = ((c_edge / P) + 2) * P;
    cur_a = na; cur_b = nb;
    sel_a = na; sel_b = nb;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] na, nb;
    sel_a = 8'h24; sel_b = 8'h91;
    cur_a = sel_a; cur_b = sel_b; prev_a = sel_a; prev_b = sel_b;
    repeat (4) begin
      @(posedge clk);
      @(negedge clk);
      checks++;
      if (clk_out !== 8'h00) begin
        fails++;
        $display("FAIL R9 in reset: got %h expected 00", clk_out);
      end
    end
    rst = 1'b0;
    j = 0; c_edge = 0; e2 = P; prev_e2 = P;
    run(6 * P);
    // rotate every code pair through every group
    for (int s = 0; s < 9; s++) begin
      for (int g = 0; g < 4; g++) begin
        int idx;
        idx = (s + 2 * g) % 9;
        na[2*g+:2] = 2'(idx / 3);
        nb[2*g+:2] = 2'(idx % 3);
      end
      change(na, nb);
      run(6 * P + 7 * s + 3);
    end
    // reserved code behaves as MID
    change(8'hFF, 8'hFF);
    run(4 * P);
    // change landing exactly on a period boundary
    run((P - ((j + 1) % P)) % P);
    change(8'hA0, 8'h50);
    run(7 * P);
    // second change inside a running blank
    change(8'hAA, 8'hAA);
    run(5);
    change(8'hA8, 8'h14);
    run(7 * P + 11);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule